// File: doc/BRIEF.md
# Tick-Paced TDM Frame Clock Generator

This block drives the timing side of a two-slot TDM audio link from one fast reference clock. Each rising clock edge is one tick (10 ns in the intended system). The block makes a bit clock at an average of 1.024 MHz and a frame sync at exactly 16 kHz, with no PLL. The ideal half-period of the bit clock is 48.828 ticks. Each half-period is therefore a whole number of ticks, 48 or 49, chosen from a constant 64-entry spacing table. The table covers one 32-bit slot and sums to exactly 3125 ticks, so every slot boundary falls on the ideal grid and the error never builds up.

On the same timing, the block works in both directions. It shifts a two-slot frame in from the microphone line and returns each slot's 24-bit sample sign-extended to 32 bits. It also shifts a two-slot frame out toward a DAC, with the sample width selectable at run time. Frames are 64 bit clocks long, and the first bit of slot 0 is marked by the frame sync.

Top module: `tdm_frame_clock_gen`

## Requirements
- R1: After reset, bclk is low, fsync is high, sdout is low and rx_valid is low.
- R2: Half-periods are numbered from reset, and k is the number modulo 64. Half-period k lasts 48 + floor((k+1)*53/64) - floor(k*53/64) ticks. Every group of 64 half-periods therefore takes 3125 ticks, and the first half after reset is low.
- R3: A frame is 64 bit-clock periods, which is 6250 ticks (16 kHz at a 10 ns tick).
- R4: fsync is high for exactly the first bit of each frame, and it changes only on the tick where bclk falls.
- R5: sdout changes only where bclk falls. It sends MSB first, slot 0 then slot 1, and the first bit of each frame is bit 31 of the slot 0 word.
- R6: The tx_width code selects the DAC sample width W: 0 gives 32, 1 gives 24, 2 gives 20 and 3 gives 16. The slot word is the low W bits of the tx input placed in slot bits 31 down to 32-W, and the remaining low bits are zero.
- R7: tx_slot0, tx_slot1 and tx_width are sampled only at the bclk fall that starts a frame. A change during a frame has no effect on that frame.
- R8: sdin is sampled on each rising bclk edge, MSB first, slot 0 first.
- R9: Each rx_slotN output is bits 31..8 of its received slot word, sign-extended to 32 bits. Bits 7..0 are ignored.
- R10: rx_valid rises on the tick where bclk rises in the last bit of a frame. It is high for exactly one cycle per frame, and it is never high while fsync is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_slot0 | input | 32 | DAC sample for slot 0 (low W bits used) |
| tx_slot1 | input | 32 | DAC sample for slot 1 (low W bits used) |
| tx_width | input | 2 | DAC sample width code |
| sdin | input | 1 | Serial data from the microphone |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, high during bit 0 |
| sdout | output | 1 | Serial data toward the DAC |
| rx_valid | output | 1 | One-cycle strobe for a completed received frame |
| rx_slot0 | output | 32 | Received slot 0 sample, sign-extended |
| rx_slot1 | output | 32 | Received slot 1 sample, sign-extended |

## Verification
Every output is registered, so each result appears on the same tick edge as the bclk transition that causes it:
- fsync and sdout move together with the falling bclk.
- rx_valid and the new rx samples appear together with the bclk rise in bit 63.
- The tx inputs take effect on the frame-start fall, and the first bit leaves on that same edge.

The bench samples every port at the falling clock edge. It detects a bclk transition by comparing the current level with the level at the previous falling edge, and it reads sdout and fsync at a detected rise and rx outputs when it sees rx_valid. It feeds sdin at each detected fall, so the data is stable long before the next rise. Half-period lengths and frame periods are measured as counts of falling edges between detected transitions. Because of this, the two-cycle reset synchronizer at the start does not shift any expected value.

// File: rtl/tdm_clk_pkg.sv
package tdm_clk_pkg;

  typedef enum logic [1:0] {
    DAC_W32 = 2'd0,
    DAC_W24 = 2'd1,
    DAC_W20 = 2'd2,
    DAC_W16 = 2'd3
  } dac_width_e;

  function automatic int unsigned dac_bits(input dac_width_e w);
    case (w)
      DAC_W32: return 32;
      DAC_W24: return 24;
      DAC_W20: return 20;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/tdm_edge_pacer.sv
module tdm_edge_pacer #(
  parameter int TICKS_PER_GROUP = 3125,
  parameter int HALVES          = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int BASE = TICKS_PER_GROUP / HALVES;
  localparam int REM  = TICKS_PER_GROUP - BASE * HALVES;
  localparam int IW   = $clog2(HALVES);
  localparam int CW   = $clog2(BASE + 2);

  function automatic logic [CW-1:0] span_of(input int idx);
    int extra;
    extra = ((idx + 1) * REM) / HALVES - (idx * REM) / HALVES;
    return CW'(BASE + extra);
  endfunction

  // Constant spacing table, one entry per half-period of a group
  logic [CW-1:0] span_tbl [HALVES];
  for (genvar g = 0; g < HALVES; g++) begin : g_span
    assign span_tbl[g] = span_of(g);
  end

  logic [IW-1:0] half_q, half_d;
  logic [CW-1:0] tick_q, tick_d;
  logic          bclk_d;
  logic          half_end;

  always_comb begin
    half_end = (tick_q == span_tbl[half_q] - 1'b1);
    tick_d   = half_end ? '0 : tick_q + 1'b1;
    half_d   = half_q;
    bclk_d   = bclk;
    if (half_end) begin
      half_d = (half_q == IW'(HALVES - 1)) ? '0 : half_q + 1'b1;
      bclk_d = ~bclk;
    end
    rise_stb = half_end & ~bclk;
    fall_stb = half_end & bclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      half_q <= '0;
      bclk   <= 1'b0;
    end else begin
      tick_q <= tick_d;
      half_q <= half_d;
      bclk   <= bclk_d;
    end
  end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int SLOT_BITS = 32,
  parameter int MIC_BITS  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_stb,
  input  logic                 last_bit,
  input  logic                 sdin,
  output logic                 rx_valid,
  output logic [SLOT_BITS-1:0] rx_slot0,
  output logic [SLOT_BITS-1:0] rx_slot1
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int PAD        = SLOT_BITS - MIC_BITS;

  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [SLOT_BITS-1:0]  ext   [2];
  logic [SLOT_BITS-1:0]  slot0_d, slot1_d;
  logic                  valid_d;

  always_comb shreg_d = rise_stb ? {shreg_q[FRAME_BITS-2:0], sdin} : shreg_q;

  // Per-slot extraction of the top MIC_BITS, sign-extended
  for (genvar s = 0; s < 2; s++) begin : g_slot
    localparam int TOP = FRAME_BITS - 1 - s * SLOT_BITS;
    assign ext[s] = {{PAD{shreg_d[TOP]}}, shreg_d[TOP -: MIC_BITS]};
  end

  always_comb begin
    valid_d = rise_stb & last_bit;
    slot0_d = valid_d ? ext[0] : rx_slot0;
    slot1_d = valid_d ? ext[1] : rx_slot1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      rx_valid <= 1'b0;
      rx_slot0 <= '0;
      rx_slot1 <= '0;
    end else begin
      shreg_q  <= shreg_d;
      rx_valid <= valid_d;
      rx_slot0 <= slot0_d;
      rx_slot1 <= slot1_d;
    end
  end

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_clk_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_stb,
  input  logic                 last_bit,
  input  logic [SLOT_BITS-1:0] tx_slot0,
  input  logic [SLOT_BITS-1:0] tx_slot1,
  input  logic [1:0]           tx_width,
  output logic                 sdout
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;

  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [SLOT_BITS-1:0]  word0, word1;
  int unsigned           lsh;

  always_comb begin
    lsh   = SLOT_BITS - dac_bits(dac_width_e'(tx_width));
    word0 = SLOT_BITS'(tx_slot0 << lsh);
    word1 = SLOT_BITS'(tx_slot1 << lsh);
    if (fall_stb && last_bit)
      shreg_d = {word0, word1};
    else if (fall_stb)
      shreg_d = {shreg_q[FRAME_BITS-2:0], 1'b0};
    else
      shreg_d = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign sdout = shreg_q[FRAME_BITS-1];

endmodule

// File: rtl/tdm_frame_clock_gen.sv
module tdm_frame_clock_gen #(
  parameter int TICKS_PER_GROUP = 3125,
  parameter int SLOT_BITS       = 32,
  parameter int MIC_BITS        = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOT_BITS-1:0] tx_slot0,
  input  logic [SLOT_BITS-1:0] tx_slot1,
  input  logic [1:0]           tx_width,
  input  logic                 sdin,
  output logic                 bclk,
  output logic                 fsync,
  output logic                 sdout,
  output logic                 rx_valid,
  output logic [SLOT_BITS-1:0] rx_slot0,
  output logic [SLOT_BITS-1:0] rx_slot1
);
  localparam int HALVES     = 2 * SLOT_BITS;
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int BW         = $clog2(FRAME_BITS);

  logic [1:0]    rst_pipe;
  logic          core_rst_n;
  logic          rise_stb, fall_stb, last_bit;
  logic [BW-1:0] bit_q, bit_d;
  logic          fsync_d;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  tdm_edge_pacer #(.TICKS_PER_GROUP(TICKS_PER_GROUP), .HALVES(HALVES)) u_pacer (
    .clk(clk), .rst_n(core_rst_n), .bclk(bclk),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  always_comb begin
    last_bit = (bit_q == BW'(FRAME_BITS - 1));
    bit_d    = bit_q;
    fsync_d  = fsync;
    if (fall_stb) begin
      bit_d   = last_bit ? '0 : bit_q + 1'b1;
      fsync_d = last_bit;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      bit_q <= '0;
      fsync <= 1'b1;
    end else begin
      bit_q <= bit_d;
      fsync <= fsync_d;
    end
  end

  tdm_rx_deser #(.SLOT_BITS(SLOT_BITS), .MIC_BITS(MIC_BITS)) u_rx (
    .clk(clk), .rst_n(core_rst_n), .rise_stb(rise_stb), .last_bit(last_bit),
    .sdin(sdin), .rx_valid(rx_valid), .rx_slot0(rx_slot0), .rx_slot1(rx_slot1)
  );

  tdm_tx_ser #(.SLOT_BITS(SLOT_BITS)) u_tx (
    .clk(clk), .rst_n(core_rst_n), .fall_stb(fall_stb), .last_bit(last_bit),
    .tx_slot0(tx_slot0), .tx_slot1(tx_slot1), .tx_width(tx_width), .sdout(sdout)
  );

endmodule

// File: rtl/tdm_frame_clock_checker.sv
module tdm_frame_clock_checker #(
  parameter int BASE_TICKS = 48
) (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic fsync,
  input logic sdout,
  input logic rx_valid
);
  logic [7:0] run;
  logic       p_bclk;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      p_bclk <= 1'b0;
      seen   <= 1'b0;
    end else begin
      p_bclk <= bclk;
      if (bclk != p_bclk) begin
        run  <= 8'd1;
        seen <= 1'b1;
      end else begin
        run <= run + 8'd1;
      end
    end
  end

  // R2: every full half-period is BASE or BASE+1 ticks
  assert_half_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && bclk != p_bclk) |-> (run == 8'(BASE_TICKS) || run == 8'(BASE_TICKS + 1)));

  // R4: fsync moves only with a falling bclk
  assert_fsync_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $fell(bclk));

  // R5: sdout moves only with a falling bclk
  assert_sdout_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $fell(bclk));

  // R10: single-cycle strobe
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: strobe lands in the high phase of the last bit
  assert_valid_placement_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (bclk && !fsync));

endmodule

bind tdm_frame_clock_gen tdm_frame_clock_checker #(
  .BASE_TICKS(TICKS_PER_GROUP / (2 * SLOT_BITS))
) u_checker (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
  .sdout(sdout), .rx_valid(rx_valid)
);

// File: tb/tdm_frame_clock_gen_bench.sv
`timescale 1ns/1ps
module tdm_frame_clock_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tx_slot0, tx_slot1;
  logic [1:0]  tx_width;
  logic        sdin;
  logic        bclk, fsync, sdout, rx_valid;
  logic [31:0] rx_slot0, rx_slot1;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tdm_frame_clock_gen u_tdm_frame_clock_gen (
    .clk(clk), .rst_n(rst_n), .tx_slot0(tx_slot0), .tx_slot1(tx_slot1),
    .tx_width(tx_width), .sdin(sdin), .bclk(bclk), .fsync(fsync),
    .sdout(sdout), .rx_valid(rx_valid), .rx_slot0(rx_slot0), .rx_slot1(rx_slot1)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hlen(input int k);
    return 48 + ((k + 1) * 53) / 64 - (k * 53) / 64;
  endfunction

  function automatic logic [31:0] tx_word(input logic [31:0] x, input logic [1:0] w);
    int bits;
    bits = (w == 2'd0) ? 32 : (w == 2'd1) ? 24 : (w == 2'd2) ? 20 : 16;
    return x << (32 - bits);
  endfunction

  function automatic logic [31:0] rx_exp(input logic [31:0] w);
    return {{8{w[31]}}, w[31:8]};
  endfunction

  // Port monitor acting as the link peer
  bit          mon_on = 1'b0;
  logic        pb, pv;
  int          bidx, h, tcnt, fcnt, frame_no, valid_no;
  bit          seen_tog, seen_frame;
  logic [63:0] rx_cur, rx_next, txbits, last_tx;
  logic [31:0] got0, got1;

  always @(negedge clk) begin
    if (!mon_on) begin
      pb = bclk; pv = 1'b0; bidx = 0; h = 0; tcnt = 0; fcnt = 0;
      seen_tog = 1'b0; seen_frame = 1'b0; rx_cur = '0; txbits = '0;
      sdin = 1'b0;
    end else begin
      tcnt++; fcnt++;
      if (bclk != pb) begin
        if (seen_tog) chk(tcnt == hlen(h), "R2 half-period length", tcnt, hlen(h));
        seen_tog = 1'b1; h = (h + 1) % 64; tcnt = 0;
        if (bclk) begin
          txbits[63 - bidx] = sdout;
          chk(fsync == (bidx == 0), "R4 fsync only in bit 0", fsync, bidx == 0);
        end else begin
          if (fsync) begin
            if (seen_frame) chk(fcnt == 6250, "R3 frame period", fcnt, 6250);
            seen_frame = 1'b1; fcnt = 0;
            last_tx = txbits; rx_cur = rx_next; bidx = 0; frame_no++;
          end else begin
            bidx++;
          end
          sdin = rx_cur[63 - bidx];
        end
      end
      if (rx_valid) begin
        if (pv) chk(1'b0, "R10 strobe longer than one cycle", 1, 0);
        got0 = rx_slot0; got1 = rx_slot1; valid_no++;
      end
      pv = rx_valid;
      pb = bclk;
    end
  end

  // One frame exchange: rx pattern in, tx words out (R5 R6 R8 R9 R10)
  task automatic run_frame(input string tag, input logic [63:0] rx_pat, input logic [31:0] t0,
                           input logic [31:0] t1, input logic [1:0] w, input bit mid_change);
    int f0, v0;
    logic [63:0] exp_tx;
    rx_next = rx_pat; tx_slot0 = t0; tx_slot1 = t1; tx_width = w;
    exp_tx = {tx_word(t0, w), tx_word(t1, w)};
    f0 = frame_no;
    wait (frame_no == f0 + 1);
    v0 = valid_no;
    if (mid_change) begin
      repeat (1500) @(negedge clk);
      tx_slot0 = ~t0; tx_slot1 = ~t1; tx_width = w + 2'd1;  // R7: must not affect this frame
    end
    wait (valid_no == v0 + 1);
    chk(got0 == rx_exp(rx_pat[63:32]), {tag, " R9 R8 rx slot0"}, got0, rx_exp(rx_pat[63:32]));
    chk(got1 == rx_exp(rx_pat[31:0]),  {tag, " R9 R8 rx slot1"}, got1, rx_exp(rx_pat[31:0]));
    wait (frame_no == f0 + 2);
    chk(valid_no == v0 + 1, {tag, " R10 one strobe per frame"}, valid_no - v0, 1);
    chk(last_tx == exp_tx, {tag, mid_change ? " R7 tx held for frame" : " R5 R6 tx serial word"},
        last_tx, exp_tx);
  endtask

  initial begin
    frame_no = 0; valid_no = 0; rx_next = '0; last_tx = '0;
    tx_slot0 = '0; tx_slot1 = '0; tx_width = 2'd0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(bclk == 1'b0, "R1 bclk", bclk, 0);
    chk(fsync == 1'b1, "R1 fsync", fsync, 1);
    chk(sdout == 1'b0, "R1 sdout", sdout, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    mon_on = 1'b1;
    rst_n  = 1'b1;
    run_frame("w32",  64'hF012_345A_7FFF_FF11, 32'h1234_5678, 32'h9ABC_DEF0, 2'd0, 1'b0);
    run_frame("w24",  64'h0000_01FF_8000_0000, 32'hFFAB_CDEF, 32'h0055_AA33, 2'd1, 1'b0);
    run_frame("w20",  64'hA5A5_5A5A_0123_4567, 32'h000F_EDCB, 32'hFFF1_2345, 2'd2, 1'b0);
    run_frame("w16",  64'hFFFF_FFFF_0000_00FF, 32'h1234_BEEF, 32'h0000_8001, 2'd3, 1'b0);
    run_frame("hold", 64'h8000_00FF_7FFF_FF00, 32'hC3C3_3C3C, 32'h0F0F_F0F0, 2'd0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule